// File: doc/BRIEF.md
# Timed Multi-Channel Conversion Start Scheduler

This block decides when an 8-channel analog converter should start a conversion, and which channel, gain code and input mode go with each start. Software writes a 32-bit control word together with a rate divisor, and it loads a packed table that holds one gain code per channel. The scheduler then issues one-cycle start strobes. Each strobe carries the channel index, the gain code actually applied and the single-ended/differential selection.

The block has three modes. The first converts one named channel. The second sweeps from channel 0 up to a programmed last channel and uses one global gain. The third performs the same sweep but takes each channel's gain from the table. A fourth mode code changes the last channel and the gain of a sweep that is already running, without restarting it. When the divisor is zero, a GO write produces one conversion, or one full sweep, paced only by the converter's done pulses. When the divisor is non-zero, one start is issued every `rateDiv` clock cycles until GO is cleared. The block never starts a conversion while the previous one has not reported done. A timer tick that cannot be served is recorded in a sticky overrun flag.

Top module: `adcScanSeq`

## Requirements
- R1: After reset, `startStrobe`, `busy` and `rateOverrun` are 0.
- R2: Control word fields: bit 0 GO, bits 2:1 mode, bits 5:3 last channel, bits 8:6 global gain, bit 9 single-ended, bit 10 low-speed. In mode 00 every start carries the last-channel field as its channel, the global gain and the single-ended bit.
- R3: In mode 11 the starts step through channels 0, 1, … up to the last channel and then wrap to 0. Every start carries the global gain.
- R4: In mode 10 the channel order is the same as in mode 11, but the gain is `gainTable[4*ch+2 : 4*ch]`. The global gain field and each nibble's bit 3 have no effect.
- R5: A GO write with a zero divisor gives exactly one start in mode 00, or exactly one sweep 0..last in the sequenced modes. Each start after the first is issued only after the previous start's done.
- R6: A GO write with divisor D ≠ 0 gives its first start strobe two cycles after the write cycle, then one start every D cycles.
- R7: No start is issued while `busy` (a start has been issued and its `convDone` has not yet arrived). A tick that finds the block busy issues nothing and sets `rateOverrun`, which stays set until the next control write.
- R8: A tick in the same cycle as `convDone` is served: it does not set the overrun flag, and the next start follows one cycle later.
- R9: A control write in mode 00, 10 or 11 with GO = 0 stops the timer and the sweep, so no further start is issued. The next GO write starts again at channel 0.
- R10: A write in mode 01 changes the last channel, the global gain and the single-ended bit of a running basic sweep. It ignores GO and it neither restarts nor stops the sweep.
- R11: `lowSpeed` reflects bit 10. With the base clock at 10 MHz and a non-zero divisor, `rateMismatch` is 1 when the divisor is above 10000 and the flag is 0, or when the divisor is 11 or less and the flag is 1; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrite | input | 1 | One-cycle write strobe for `ctrlWord` and `rateDiv` |
| ctrlWord | input | 32 | Control word (fields listed in R2) |
| rateDiv | input | 16 | Start period in base clock cycles; 0 selects one-shot operation |
| gainTable | input | 32 | Per-channel gain, one nibble per channel |
| convDone | input | 1 | Converter finished the current conversion |
| startStrobe | output | 1 | One-cycle conversion start |
| startChan | output | 3 | Channel of the current start |
| startGain | output | 3 | Gain code of the current start |
| startSingleEnded | output | 1 | 1 = input versus common, 0 = differential |
| lowSpeed | output | 1 | Low-speed setting as written |
| rateMismatch | output | 1 | Divisor and low-speed setting disagree |
| rateOverrun | output | 1 | Sticky: a rate tick was lost because the block was busy |
| busy | output | 1 | A conversion is outstanding |

## Verification
The rate tick and the converter's done pulse can land in the same cycle. The bench provokes this by giving the converter model a latency one cycle shorter than the period, so that done arrives exactly on the following tick. The bench then expects evenly spaced starts and a clear overrun flag. A second run lengthens the latency by one cycle. Now the tick meets a busy block, and the bench expects the overrun flag to be set and the start spacing to double.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;
  localparam int CHAN_W   = 3;
  localparam int GAIN_W   = 3;
  localparam int NIB_W    = 4;
  localparam int NCHAN    = 1 << CHAN_W;

  localparam int GO_BIT   = 0;
  localparam int MODE_LSB = 1;
  localparam int LAST_LSB = 3;
  localparam int GAIN_LSB = 6;
  localparam int SE_BIT   = 9;
  localparam int LOW_BIT  = 10;
  localparam int FIELD_W  = 11;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_UPDATE = 2'b01,
    MODE_ADV    = 2'b10,
    MODE_BASIC  = 2'b11
  } seqMode_e;

  typedef struct packed {
    logic              issue;
    logic [CHAN_W-1:0] chan;
  } issueCmd_t;
endpackage

// File: rtl/adcSeqDatapath.sv
module adcSeqDatapath
  import adcSeqPkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int BASE_HZ = 10_000_000,
  parameter int SLOW_HZ = 1_000,
  parameter int FAST_HZ = 900_000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ctrlWrite,
  input  logic [FIELD_W-1:0]      fields,
  input  logic [DIV_W-1:0]        rateDiv,
  input  logic [NCHAN*NIB_W-1:0]  gainTable,
  input  issueCmd_t               cmd,
  output seqMode_e                cfgMode,
  output logic [CHAN_W-1:0]       cfgLast,
  output logic [DIV_W-1:0]        cfgDiv,
  output logic                    startStrobe,
  output logic [CHAN_W-1:0]       startChan,
  output logic [GAIN_W-1:0]       startGain,
  output logic                    startSingleEnded,
  output logic                    lowSpeed,
  output logic                    rateMismatch
);
  localparam logic [DIV_W-1:0] SLOW_DIV = DIV_W'(BASE_HZ / SLOW_HZ);
  localparam logic [DIV_W-1:0] FAST_DIV = DIV_W'((BASE_HZ - 1) / FAST_HZ);

  logic [GAIN_W-1:0] cfgGain;
  logic              cfgSe;
  logic [GAIN_W-1:0] chanGain [NCHAN];
  seqMode_e          wrMode;

  assign wrMode = seqMode_e'(fields[MODE_LSB +: 2]);

  for (genvar i = 0; i < NCHAN; i++) begin : g_nib
    assign chanGain[i] = gainTable[i*NIB_W +: GAIN_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgMode  <= MODE_SINGLE;
      cfgLast  <= '0;
      cfgGain  <= '0;
      cfgSe    <= 1'b0;
      lowSpeed <= 1'b0;
      cfgDiv   <= '0;
    end else if (ctrlWrite) begin
      cfgLast <= fields[LAST_LSB +: CHAN_W];
      cfgGain <= fields[GAIN_LSB +: GAIN_W];
      cfgSe   <= fields[SE_BIT];
      if (wrMode == MODE_UPDATE) begin
        cfgMode <= MODE_BASIC;
      end else begin
        cfgMode  <= wrMode;
        lowSpeed <= fields[LOW_BIT];
        cfgDiv   <= rateDiv;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startStrobe      <= 1'b0;
      startChan        <= '0;
      startGain        <= '0;
      startSingleEnded <= 1'b0;
    end else begin
      startStrobe <= cmd.issue;
      if (cmd.issue) begin
        startChan        <= cmd.chan;
        startGain        <= (cfgMode == MODE_ADV) ? chanGain[cmd.chan] : cfgGain;
        startSingleEnded <= cfgSe;
      end
    end
  end

  always_comb begin
    rateMismatch = 1'b0;
    if (cfgDiv != '0) begin
      rateMismatch = (cfgDiv > SLOW_DIV && !lowSpeed) ||
                     (cfgDiv <= FAST_DIV && lowSpeed);
    end
  end
endmodule

// File: rtl/adcSeqControl.sv
module adcSeqControl
  import adcSeqPkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrite,
  input  logic              wrGo,
  input  seqMode_e          wrMode,
  input  seqMode_e          cfgMode,
  input  logic [CHAN_W-1:0] cfgLast,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic              convDone,
  output issueCmd_t         cmd,
  output logic              busy,
  output logic              rateOverrun
);
  logic              running, want, lastWasLast;
  logic [CHAN_W-1:0] ptr, issueChan;
  logic [DIV_W-1:0]  cnt;
  logic              wrStart, wrStop, seqOn, slotFree, timed, tick, issue, doneNow;

  assign wrStart   = ctrlWrite && (wrMode != MODE_UPDATE) && wrGo;
  assign wrStop    = ctrlWrite && (wrMode != MODE_UPDATE) && !wrGo;
  assign seqOn     = (cfgMode == MODE_ADV) || (cfgMode == MODE_BASIC);
  assign doneNow   = busy && convDone;
  assign slotFree  = !busy || convDone;
  assign timed     = running && (cfgDiv != '0);
  assign tick      = timed && (cnt == cfgDiv - DIV_W'(1));
  assign issueChan = !seqOn ? cfgLast : ((ptr > cfgLast) ? '0 : ptr);
  assign issue     = want && !busy && !ctrlWrite;
  assign cmd       = '{issue: issue, chan: issueChan};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running     <= 1'b0;
      want        <= 1'b0;
      lastWasLast <= 1'b0;
      ptr         <= '0;
      cnt         <= '0;
      rateOverrun <= 1'b0;
    end else if (wrStart || wrStop) begin
      running     <= wrStart;
      want        <= wrStart;
      lastWasLast <= 1'b0;
      ptr         <= '0;
      cnt         <= '0;
      rateOverrun <= 1'b0;
    end else begin
      if (ctrlWrite) rateOverrun <= 1'b0;
      if (timed) cnt <= tick ? '0 : cnt + DIV_W'(1);
      if (issue) begin
        want        <= 1'b0;
        ptr         <= (issueChan == cfgLast) ? '0 : issueChan + CHAN_W'(1);
        lastWasLast <= !seqOn || (issueChan == cfgLast);
      end
      if (tick) begin
        if (!slotFree || want) rateOverrun <= 1'b1;
        else                   want        <= 1'b1;
      end
      if (doneNow && running && cfgDiv == '0) begin
        if (lastWasLast) running <= 1'b0;
        else             want    <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        busy <= 1'b0;
    else if (issue)   busy <= 1'b1;
    else if (doneNow) busy <= 1'b0;
  end
endmodule

// File: rtl/adcScanSeq.sv
module adcScanSeq
  import adcSeqPkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int BASE_HZ = 10_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrite,
  input  logic [31:0]       ctrlWord,
  input  logic [DIV_W-1:0]  rateDiv,
  input  logic [31:0]       gainTable,
  input  logic              convDone,
  output logic              startStrobe,
  output logic [2:0]        startChan,
  output logic [2:0]        startGain,
  output logic              startSingleEnded,
  output logic              lowSpeed,
  output logic              rateMismatch,
  output logic              rateOverrun,
  output logic              busy
);
  seqMode_e          cfgMode;
  logic [CHAN_W-1:0] cfgLast;
  logic [DIV_W-1:0]  cfgDiv;
  issueCmd_t         cmd;
  logic              unusedCtrlBits;

  assign unusedCtrlBits = ^ctrlWord[31:FIELD_W];

  adcSeqControl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite),
    .wrGo(ctrlWord[GO_BIT]), .wrMode(seqMode_e'(ctrlWord[MODE_LSB +: 2])),
    .cfgMode(cfgMode), .cfgLast(cfgLast), .cfgDiv(cfgDiv),
    .convDone(convDone), .cmd(cmd), .busy(busy), .rateOverrun(rateOverrun)
  );

  adcSeqDatapath #(.DIV_W(DIV_W), .BASE_HZ(BASE_HZ)) dp_i (
    .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite),
    .fields(ctrlWord[FIELD_W-1:0]), .rateDiv(rateDiv), .gainTable(gainTable),
    .cmd(cmd), .cfgMode(cfgMode), .cfgLast(cfgLast), .cfgDiv(cfgDiv),
    .startStrobe(startStrobe), .startChan(startChan), .startGain(startGain),
    .startSingleEnded(startSingleEnded), .lowSpeed(lowSpeed),
    .rateMismatch(rateMismatch)
  );
endmodule

// File: rtl/adcScanSeq_chk.sv
module adcScanSeq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWrite,
  input logic [5:0] wrField,
  input logic       convDone,
  input logic       startStrobe,
  input logic [2:0] startChan,
  input logic       busy,
  input logic       rateOverrun
);
  logic [2:0] trackLast;
  logic       trackSeq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trackLast <= '0;
      trackSeq  <= 1'b0;
    end else if (ctrlWrite) begin
      trackLast <= wrField[5:3];
      if (wrField[2:1] != 2'b01) trackSeq <= wrField[2];
      else                       trackSeq <= 1'b1;
    end
  end

  assert_no_start_while_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !convDone) |=> !startStrobe);

  assert_start_marks_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |-> busy);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rateOverrun && !ctrlWrite) |=> rateOverrun);

  assert_chan_in_sweep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (startStrobe && trackSeq) |-> (startChan <= trackLast));

  assert_stop_no_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && wrField[2:1] != 2'b01 && !wrField[0]) |=> !startStrobe);
endmodule

bind adcScanSeq adcScanSeq_chk chk_i (
  .clk(clk), .rstN(rstN), .ctrlWrite(ctrlWrite), .wrField(ctrlWord[5:0]),
  .convDone(convDone), .startStrobe(startStrobe), .startChan(startChan),
  .busy(busy), .rateOverrun(rateOverrun)
);

// File: tb/adcScanSeq_tb_top.sv
module adcScanSeq_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrite = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic [15:0] rateDiv = '0;
  logic [31:0] gainTable = '0;
  logic        convDone = 1'b0;
  logic        startStrobe, startSingleEnded, lowSpeed, rateMismatch, rateOverrun, busy;
  logic [2:0]  startChan, startGain;

  int checks = 0, fails = 0, cyc = 0, wrCyc = 0;
  int ackLat = 3, rem = 0, logN = 0;
  int logChan [64];
  int logGain [64];
  int logSe [64];
  int logCyc [64];

  adcScanSeq dut_i (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    convDone = 1'b0;
    if (rem > 0) begin rem--; if (rem == 0) convDone = 1'b1; end
    if (startStrobe) begin
      if (logN < 64) begin
        logChan[logN] = startChan; logGain[logN] = startGain;
        logSe[logN] = startSingleEnded; logCyc[logN] = cyc;
      end
      logN++;
      if (ackLat <= 1) convDone = 1'b1; else rem = ackLat - 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk); rstN = 1'b0; ctrlWrite = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1; rem = 0; logN = 0;
  endtask

  task automatic writeCtrl(bit go, bit [1:0] mode, bit [2:0] last, bit [2:0] gain,
                           bit se, bit low, bit [15:0] div);
    @(negedge clk);
    ctrlWord = {21'd0, low, se, gain, last, mode, go};
    rateDiv = div; ctrlWrite = 1'b1; wrCyc = cyc;
    @(negedge clk);
    ctrlWrite = 1'b0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk); rstN = 1'b0;
    waitCyc(2);
    chk("R1 strobe", startStrobe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 overrun", rateOverrun, 0);
    rstN = 1'b1;
  endtask

  task automatic testSingle();
    resetDut(); ackLat = 3;
    writeCtrl(1, 2'b00, 3'd5, 3'd3, 1, 0, 16'd0);
    waitCyc(30);
    chk("R5 single count", logN, 1);
    chk("R2 chan", logChan[0], 5);
    chk("R2 gain", logGain[0], 3);
    chk("R2 single-ended", logSe[0], 1);
    chk("R5 idle after", busy, 0);
  endtask

  task automatic testBasicOnce();
    resetDut(); ackLat = 2;
    writeCtrl(1, 2'b11, 3'd3, 3'd6, 0, 0, 16'd0);
    waitCyc(60);
    chk("R5 sweep count", logN, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 chan order", logChan[i], i);
      chk("R3 global gain", logGain[i], 6);
      chk("R2 differential", logSe[i], 0);
    end
  endtask

  task automatic testAdvTimed();
    int n;
    int expG [3] = '{2, 5, 4};
    resetDut(); ackLat = 3;
    gainTable = 32'h0000_0C5A;
    writeCtrl(1, 2'b10, 3'd2, 3'd7, 0, 0, 16'd20);
    waitCyc(129);
    chk("R6 timed count", logN, 7);
    chk("R6 first start offset", logCyc[0] - wrCyc, 2);
    for (int i = 0; i < 6; i++) begin
      chk("R4 chan order", logChan[i], i % 3);
      chk("R4 table gain", logGain[i], expG[i % 3]);
      if (i > 0) chk("R6 period", logCyc[i] - logCyc[i-1], 20);
    end
    chk("R7 no false overrun", rateOverrun, 0);
    writeCtrl(0, 2'b10, 3'd2, 3'd7, 0, 0, 16'd20);
    n = logN;
    waitCyc(60);
    chk("R9 stopped", logN, n);
    writeCtrl(1, 2'b11, 3'd2, 3'd1, 0, 0, 16'd20);
    waitCyc(5);
    chk("R9 restart count", logN, n + 1);
    chk("R9 restart at 0", logChan[n], 0);
    writeCtrl(0, 2'b11, 3'd2, 3'd1, 0, 0, 16'd0);
  endtask

  task automatic testOverrun();
    resetDut(); ackLat = 8;
    writeCtrl(1, 2'b00, 3'd1, 3'd0, 0, 0, 16'd4);
    waitCyc(60);
    chk("R7 overrun set", rateOverrun, 1);
    chk("R7 spacing when busy", logCyc[1] - logCyc[0], 12);
    chk("R7 spacing again", logCyc[2] - logCyc[1], 12);
    writeCtrl(0, 2'b00, 3'd1, 3'd0, 0, 0, 16'd4);
    chk("R7 cleared by write", rateOverrun, 0);
  endtask

  task automatic testCoincide();
    resetDut(); ackLat = 9;
    writeCtrl(1, 2'b00, 3'd4, 3'd2, 0, 0, 16'd10);
    waitCyc(80);
    chk("R8 no overrun", rateOverrun, 0);
    chk("R8 spacing", logCyc[2] - logCyc[1], 10);
    chk("R8 chan", logChan[2], 4);
    resetDut(); ackLat = 10;
    writeCtrl(1, 2'b00, 3'd4, 3'd2, 0, 0, 16'd10);
    waitCyc(80);
    chk("R8 late done overrun", rateOverrun, 1);
    chk("R8 late done spacing", logCyc[2] - logCyc[1], 20);
  endtask

  task automatic testUpdate();
    int guard = 0;
    resetDut(); ackLat = 6;
    writeCtrl(1, 2'b11, 3'd7, 3'd1, 0, 0, 16'd0);
    while (logN < 2 && guard < 100) begin @(negedge clk); guard++; end
    writeCtrl(0, 2'b01, 3'd3, 3'd5, 1, 0, 16'd0);
    waitCyc(60);
    chk("R10 count", logN, 4);
    chk("R10 chan2", logChan[2], 2);
    chk("R10 chan3", logChan[3], 3);
    chk("R10 gain old", logGain[1], 1);
    chk("R10 gain new", logGain[2], 5);
    chk("R10 se new", logSe[3], 1);
  endtask

  task automatic mis(bit [15:0] div, bit low, int exp);
    writeCtrl(0, 2'b00, 3'd0, 3'd0, 0, low, div);
    chk("R11 lowSpeed", lowSpeed, low);
    chk("R11 mismatch", rateMismatch, exp);
  endtask

  task automatic testLowSpeed();
    resetDut();
    mis(16'd20000, 0, 1);
    mis(16'd20000, 1, 0);
    mis(16'd10000, 0, 0);
    mis(16'd10001, 0, 1);
    mis(16'd11, 1, 1);
    mis(16'd12, 1, 0);
    mis(16'd5, 0, 0);
    mis(16'd0, 1, 0);
  endtask

  initial begin
    testReset();
    testSingle();
    testBasicOnce();
    testAdvTimed();
    testOverrun();
    testCoincide();
    testUpdate();
    testLowSpeed();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule